// File: doc/BRIEF.md
# Double-Buffer Region Selector

This block decides which of two equally sized regions in a shared memory currently holds the buffer to be read, and which should be filled next. A producer ends each region with a 16-bit frame counter and bumps it every audio tick. The selector watches the memory write bus, picks up halfword writes aimed at either counter slot, and keeps its own copy of both counters.

From the two counters it picks the read region and names the other one as the write region. It also gives the base byte address of each. Normally the region with the strictly larger counter is read. A special rule covers a counter that has just reached its maximum while the other has already wrapped past zero.

Counters are captured on the clock edge that follows the bus write. The selection and base outputs are registered one edge after that. A write presented before edge N is therefore visible on the outputs after edge N+1.

Top module: `region_select_top`

## Requirements
- R1: After reset both tracked counters are zero, so `rdSel` is 1, `wrSel` is 0, `rdBase` is 0x70000 and `wrBase` is 0x50000.
- R2: A halfword write with `wrEn` high to byte address 0x57FFE loads counter 0, and one to 0x77FFE loads counter 1, on the next clock edge. The outputs reflect the new value one edge later.
- R3: Writes to any other address leave both counters and all outputs unchanged.
- R4: When counter 0 is 0xFFFF and counter 1 is not 0xFFFE, region 1 is read.
- R5: When counter 1 is 0xFFFF and counter 0 is not 0xFFFE, region 0 is read, unless R4 already applies.
- R6: The R4 test is applied before the R5 test, so with both counters at 0xFFFF region 1 is read.
- R7: When neither wrap rule applies, region 0 is read only if counter 0 is strictly greater than counter 1. On a tie, or otherwise, region 1 is read.
- R8: `wrSel` is always the complement of `rdSel`.
- R9: `rdBase` and `wrBase` are the base addresses (region 0 at 0x50000, region 1 at 0x70000) of the regions named by `rdSel` and `wrSel`.
- R10: With `wrEn` low, bus activity at the counter addresses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Snooped bus write strobe (halfword) |
| wrAddr | input | 19 | Snooped byte address |
| wrData | input | 16 | Snooped halfword write data |
| rdSel | output | 1 | Index of the region to read |
| wrSel | output | 1 | Index of the region to write |
| rdBase | output | 19 | Base byte address of the read region |
| wrBase | output | 19 | Base byte address of the write region |

## Verification
The embedded assertions check on every cycle that the two indices are complementary and that each base address matches its index. They also check that at most one counter is loaded at a time, that nothing is loaded without a bus write, that a load captures the bus data, and that the first wrap rule and the plain magnitude rule drive the selection one cycle later. The second wrap rule, the ordering between the two wrap rules, the near-maximum pairs (0xFFFF against 0xFFFE) and the rejection of writes to neighbouring addresses are shown only by the directed scenarios, which compare the outputs against values derived from the rules.

// File: rtl/region_select_pkg.sv
package region_select_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [1:0]       ld;
    logic [CNT_W-1:0] value;
  } cntStrobe_t;

  function automatic logic pickRead(input logic [CNT_W-1:0] c0, input logic [CNT_W-1:0] c1);
    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] nearTop;
    top     = '1;
    nearTop = top - 1'b1;
    if (c0 == top && c1 != nearTop) return 1'b1;
    if (c1 == top && c0 != nearTop) return 1'b0;
    return (c0 > c1) ? 1'b0 : 1'b1;
  endfunction
endpackage

// File: rtl/region_select_ctrl.sv
module region_select_ctrl
  import region_select_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int R0_BASE   = 'h50000,
  parameter int R1_BASE   = 'h70000,
  parameter int REG_BYTES = 'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output cntStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] SLOT0 = ADDR_W'(R0_BASE + REG_BYTES - 2);
  localparam logic [ADDR_W-1:0] SLOT1 = ADDR_W'(R1_BASE + REG_BYTES - 2);

  always_comb begin
    strb.value = wrData;
    strb.ld[0] = wrEn && (wrAddr == SLOT0);
    strb.ld[1] = wrEn && (wrAddr == SLOT1);
  end

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.ld));

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> strb.ld == 2'b00);
endmodule

// File: rtl/region_select_dp.sv
module region_select_dp
  import region_select_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int R0_BASE = 'h50000,
  parameter int R1_BASE = 'h70000
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strb,
  output logic              rdSel,
  output logic              wrSel,
  output logic [ADDR_W-1:0] rdBase,
  output logic [ADDR_W-1:0] wrBase
);
  localparam logic [ADDR_W-1:0] BASE0 = ADDR_W'(R0_BASE);
  localparam logic [ADDR_W-1:0] BASE1 = ADDR_W'(R1_BASE);
  localparam logic [CNT_W-1:0]  TOP   = '1;
  localparam logic [CNT_W-1:0]  NEAR  = TOP - 1'b1;

  logic [CNT_W-1:0] cnt [2];
  logic             nextRd;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)            cnt[g] <= '0;
      else if (strb.ld[g])  cnt[g] <= strb.value;
    end

    // R2
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.ld[g] |=> cnt[g] == $past(strb.value));
  end

  assign nextRd = pickRead(cnt[0], cnt[1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSel  <= 1'b1;
      wrSel  <= 1'b0;
      rdBase <= BASE1;
      wrBase <= BASE0;
    end else begin
      rdSel  <= nextRd;
      wrSel  <= ~nextRd;
      rdBase <= nextRd ? BASE1 : BASE0;
      wrBase <= nextRd ? BASE0 : BASE1;
    end
  end

  // R8
  opposite_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSel != rdSel);

  // R9
  base_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdBase == (rdSel ? BASE1 : BASE0) && wrBase == (wrSel ? BASE1 : BASE0));

  // R4
  wrap_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] == TOP && cnt[1] != NEAR) |=> rdSel == 1'b1);

  // R7
  greater_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] != TOP && cnt[1] != TOP && cnt[0] > cnt[1]) |=> rdSel == 1'b0);
endmodule

// File: rtl/region_select_top.sv
module region_select_top
  import region_select_pkg::*;
#(
  parameter int MEM_BYTES = 'h80000,
  parameter int R0_BASE   = 'h50000,
  parameter int R1_BASE   = 'h70000,
  parameter int REG_BYTES = 'h8000,
  localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  output logic              rdSel,
  output logic              wrSel,
  output logic [ADDR_W-1:0] rdBase,
  output logic [ADDR_W-1:0] wrBase
);
  cntStrobe_t strb;

  region_select_ctrl #(
    .ADDR_W(ADDR_W), .R0_BASE(R0_BASE), .R1_BASE(R1_BASE), .REG_BYTES(REG_BYTES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  region_select_dp #(
    .ADDR_W(ADDR_W), .R0_BASE(R0_BASE), .R1_BASE(R1_BASE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdSel(rdSel), .wrSel(wrSel), .rdBase(rdBase), .wrBase(wrBase)
  );
endmodule

// File: tb/test_region_select_top.sv
module test_region_select_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [18:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdSel, wrSel;
  logic [18:0] rdBase, wrBase;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  localparam logic [18:0] SLOT0 = 19'h57FFE;
  localparam logic [18:0] SLOT1 = 19'h77FFE;

  always #5 clk = ~clk;

  region_select_top i_region_select_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdSel(rdSel), .wrSel(wrSel), .rdBase(rdBase), .wrBase(wrBase)
  );

  task automatic expectRead(input logic exp, input string req);
    logic [18:0] eRd;
    logic [18:0] eWr;
    eRd = exp ? 19'h70000 : 19'h50000;
    eWr = exp ? 19'h50000 : 19'h70000;
    compared++;
    if (rdSel !== exp || wrSel !== ~exp || rdBase !== eRd || wrBase !== eWr) begin
      mismatched++;
      $display("FAIL %s: rd=%0d wr=%0d rdBase=%h wrBase=%h expected rd=%0d wr=%0d rdBase=%h wrBase=%h",
               req, rdSel, wrSel, rdBase, wrBase, exp, ~exp, eRd, eWr);
    end
  endtask

  // drive at negedge, counter captured at next edge, outputs one edge later
  task automatic busWrite(input logic en, input logic [18:0] a, input logic [15:0] d);
    wrEn = en; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setPair(input logic [15:0] c0, input logic [15:0] c1);
    busWrite(1'b1, SLOT0, c0);
    busWrite(1'b1, SLOT1, c1);
  endtask

  task automatic testReset();
    expectRead(1'b1, "R1 reset");
  endtask

  task automatic testSnoop();
    busWrite(1'b1, SLOT0, 16'd7);
    expectRead(1'b0, "R2 counter0 load");
    busWrite(1'b1, SLOT1, 16'd8);
    expectRead(1'b1, "R2 counter1 load");
  endtask

  task automatic testMagnitude();
    setPair(16'd100, 16'd99);
    expectRead(1'b0, "R7 greater");
    setPair(16'd40, 16'd40);
    expectRead(1'b1, "R7 tie");
    setPair(16'd3, 16'd1000);
    expectRead(1'b1, "R7 less");
    expectRead(~rdSel ? 1'b0 : rdSel, "R8 complement");
  endtask

  task automatic testWrap();
    setPair(16'hFFFF, 16'h0002);
    expectRead(1'b1, "R4 counter0 wrap");
    setPair(16'h0001, 16'hFFFF);
    expectRead(1'b0, "R5 counter1 wrap");
    setPair(16'hFFFF, 16'hFFFE);
    expectRead(1'b0, "R4 near-max pair");
    setPair(16'hFFFE, 16'hFFFF);
    expectRead(1'b1, "R5 near-max pair");
    setPair(16'hFFFF, 16'hFFFF);
    expectRead(1'b1, "R6 both max");
  endtask

  task automatic testIgnored();
    setPair(16'd5, 16'd3);
    expectRead(1'b0, "R9 base setup");
    busWrite(1'b1, 19'h77FFC, 16'd9);
    expectRead(1'b0, "R3 adjacent address");
    busWrite(1'b1, 19'h67FFE, 16'd9);
    expectRead(1'b0, "R3 gap address");
    busWrite(1'b1, 19'h57FFF, 16'd0);
    expectRead(1'b0, "R3 odd address");
    busWrite(1'b0, SLOT1, 16'd9);
    expectRead(1'b0, "R10 enable low");
    busWrite(1'b1, SLOT1, 16'd9);
    expectRead(1'b1, "R2 load after ignored");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSnoop();
    testMagnitude();
    testWrap();
    testIgnored();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule